// File: doc/BRIEF.md
# Three-Phase Sawtooth PWM Generator

This block drives three complementary pairs of motor-bridge outputs (U, V and W, each with a positive and a negative side) using sawtooth modulation. A single down-counting carrier sets the period. Each time it reaches zero it raises an interrupt and restarts three per-phase width timers. Each output level comes from a two-bit pattern. The pattern is loaded from a buffer register at carrier zero, and its bit 0 drives the output first. When the phase's width timer expires, the pattern advances so that bit 1 drives the output.

Outputs are treated as active low. A per-phase dead-time timer makes every falling level wait before it reaches the pin, so the two sides of a pair are never low together. A rising level appears at once. A polarity bit inverts all six pins. Software programs the block through one write port: a select code and a data word. Buffer and width values are sampled only at carrier zero, so a period that is already running is never disturbed.

Top module: `tri_saw_pwm`

## Requirements
- R1: The carrier counts down by one each cycle. When it is zero, `carrier_zero` is high for that cycle and the counter reloads the period register, so with period P a zero occurs every P+1 cycles.
- R2: At each carrier zero, every phase loads its buffer nibble. Bits [1:0] go to the positive pattern and bits [3:2] to the negative pattern, and phase p uses buffer bits [4p+3:4p]. From the next cycle, bit 0 of each pattern drives its side.
- R3: With a width W sampled at the load, the pattern of that phase advances at the (W+1)-th clock edge after the load edge, and from then on bit 1 drives each side.
- R4: When a load or an advance turns a side from high to low, the side stays high for D+1 cycles (D is the dead-time register) and only then goes low.
- R5: A side that turns from low to high at a load or an advance is high in the very next cycle.
- R6: If no bit position has a 0 in both the positive and the negative pattern of a phase, that phase's two sides are never low in the same cycle.
- R7: A negative pattern of 11 holds the negative side high for the whole period while the positive side switches.
- R8: A write to a buffer or width register made during a period does not change that period's waveform. It first acts at the next carrier zero.
- R9: If W is greater than or equal to P, the phase does not advance in that period, and both sides keep their bit-0 levels until the next zero.
- R10: The polarity bit (data bit 0 of select 3) inverts all six pins from the cycle after the write.
- R11: After reset the period, dead time, widths and polarity are 0 and the buffers are all ones, so all six pins are high and `carrier_zero` is high.
- R12: Register select codes: 0 period, 1 dead time, 2 buffers, 3 polarity, 4/5/6 width of U/V/W. A write with select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | CW | Write data |
| carrier_zero | output | 1 | High while the carrier counter is zero (interrupt) |
| u_p | output | 1 | U phase positive side |
| u_n | output | 1 | U phase negative side |
| v_p | output | 1 | V phase positive side |
| v_n | output | 1 | V phase negative side |
| w_p | output | 1 | W phase positive side |
| w_n | output | 1 | W phase negative side |

## Verification
The bench checks the exact cycle of each edge inside one period.
- A design that started the dead time one cycle late, or applied it to rising edges, would move the falling edge of the positive side or delay the recovery of the negative side.
- A design that sampled the width directly, rather than at carrier zero, would advance the pattern at the wrong point in the period after a mid-period width write.
- Setting the width equal to the period catches a design that lets the width timer advance on the reload edge.

A cycle-level reference model then runs under random register writes, including select 7, and catches any drift in the reload, advance or hold timing.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int NPH   = 3;
   localparam int BUF_W = 4 * NPH;

   typedef enum logic [2:0] {
      SEL_PERIOD = 3'd0,
      SEL_DEAD   = 3'd1,
      SEL_BUF    = 3'd2,
      SEL_POL    = 3'd3,
      SEL_WID_U  = 3'd4,
      SEL_WID_V  = 3'd5,
      SEL_WID_W  = 3'd6,
      SEL_NONE   = 3'd7
   } sel_e;

   // one phase's buffer nibble: pos in [1:0], neg in [3:2]
   typedef struct packed {
      logic [1:0] neg;
      logic [1:0] pos;
   } phase_buf_t;
endpackage

// File: rtl/tsp_regs.sv
module tsp_regs
   import tsp_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DTW = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_sel,
   input  logic [CW-1:0]           wr_data,
   output logic [CW-1:0]           period,
   output logic [DTW-1:0]          dead,
   output phase_buf_t [NPH-1:0]    bufs,
   output logic                    pol,
   output logic [NPH-1:0][CW-1:0]  width
);
   sel_e sel;
   assign sel = sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period <= '0;
         dead   <= '0;
         bufs   <= {BUF_W{1'b1}};
         pol    <= 1'b0;
         width  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_PERIOD: period <= wr_data;
            SEL_DEAD:   dead   <= wr_data[DTW-1:0];
            SEL_BUF:    bufs   <= wr_data[BUF_W-1:0];
            SEL_POL:    pol    <= wr_data[0];
            SEL_WID_U:  width[0] <= wr_data;
            SEL_WID_V:  width[1] <= wr_data;
            SEL_WID_W:  width[2] <= wr_data;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/tsp_carrier.sv
module tsp_carrier #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] period,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (zero) cnt_q <= period;
      else           cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R1: reload from the period register at zero
   a_r1_reload: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> (cnt_q == $past(period)));
   // R1: otherwise step down by one
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      !zero |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/tsp_side.sv
module tsp_side (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic       sh,
   input  logic [1:0] ld_val,
   input  logic       dt_done,
   output logic       lvl,
   output logic [1:0] sr_o
);
   logic [1:0] sr_q;
   logic       hold_q;
   logic [1:0] nxt_sr;
   logic       evt;

   assign evt = ld | sh;

   always_comb begin
      if (ld) nxt_sr = ld_val;
      else    nxt_sr = {sr_q[1], sr_q[1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= 2'b11;
         hold_q <= 1'b0;
      end else if (evt) begin
         sr_q   <= nxt_sr;
         hold_q <= lvl & ~nxt_sr[0];
      end else if (dt_done) begin
         hold_q <= 1'b0;
      end
   end

   assign lvl  = sr_q[0] | hold_q;
   assign sr_o = sr_q;

   // R2: load copies the buffer bits
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (sr_o == $past(ld_val)));
   // R3: advance moves bit 1 to the driving position
   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && !ld) |=> (sr_o[0] == $past(sr_o[1])));
   // R4: a high level survives while the dead time is running
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && !evt && !dt_done) |=> lvl);
   // R5: rising levels are not delayed
   a_r5_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && nxt_sr[0]) |=> lvl);
endmodule

// File: rtl/tsp_phase.sv
module tsp_phase
   import tsp_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DTW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           zero,
   input  logic [CW-1:0]  width,
   input  logic [DTW-1:0] dead,
   input  phase_buf_t     bufv,
   output logic           lvl_p,
   output logic           lvl_n
);
   localparam int NSIDE = 2;

   logic [CW-1:0]  os_q;
   logic           run_q;
   logic [DTW-1:0] dtc_q;
   logic           shift;
   logic           dt_done;
   logic [1:0]     ldv  [NSIDE];
   logic           lvl_s[NSIDE];
   logic [1:0]     sr_s [NSIDE];

   assign shift   = run_q && (os_q == '0) && !zero;
   assign dt_done = (dtc_q == '0);
   assign ldv[0]  = bufv.pos;
   assign ldv[1]  = bufv.neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         os_q  <= '0;
         run_q <= 1'b0;
      end else if (zero) begin
         os_q  <= width;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (os_q == '0) run_q <= 1'b0;
         else            os_q  <= os_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dtc_q <= '0;
      else if (zero | shift)  dtc_q <= dead;
      else if (!dt_done)      dtc_q <= dtc_q - 1'b1;
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      tsp_side u_side (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld      (zero),
         .sh      (shift),
         .ld_val  (ldv[s]),
         .dt_done (dt_done),
         .lvl     (lvl_s[s]),
         .sr_o    (sr_s[s])
      );
   end

   assign lvl_p = lvl_s[0];
   assign lvl_n = lvl_s[1];

   // R6: complementary patterns never give two lows
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      ((sr_s[0] | sr_s[1]) == 2'b11) |-> (lvl_p || lvl_n));
   // R3: one advance per period at most
   a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> !run_q);
endmodule

// File: rtl/tri_saw_pwm.sv
module tri_saw_pwm
   import tsp_pkg::*;
#(
   parameter int CW  = 16,
   parameter int DTW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [CW-1:0] wr_data,
   output logic          carrier_zero,
   output logic          u_p,
   output logic          u_n,
   output logic          v_p,
   output logic          v_n,
   output logic          w_p,
   output logic          w_n
);
   if (CW < BUF_W) begin : g_bad_cw
      $error("CW must hold all buffer bits");
   end
   if (DTW < 1 || DTW > CW) begin : g_bad_dtw
      $error("DTW must be between 1 and CW");
   end

   logic [CW-1:0]          period;
   logic [DTW-1:0]         dead;
   phase_buf_t [NPH-1:0]   bufs;
   logic                   pol;
   logic [NPH-1:0][CW-1:0] width;
   logic                   zero;
   logic [NPH-1:0]         lp;
   logic [NPH-1:0]         ln;

   tsp_regs #(.CW(CW), .DTW(DTW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .period  (period),
      .dead    (dead),
      .bufs    (bufs),
      .pol     (pol),
      .width   (width)
   );

   tsp_carrier #(.CW(CW)) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (period),
      .zero   (zero)
   );

   for (genvar p = 0; p < NPH; p++) begin : g_phase
      tsp_phase #(.CW(CW), .DTW(DTW)) u_phase (
         .clk   (clk),
         .rst_n (rst_n),
         .zero  (zero),
         .width (width[p]),
         .dead  (dead),
         .bufv  (bufs[p]),
         .lvl_p (lp[p]),
         .lvl_n (ln[p])
      );
   end

   assign carrier_zero = zero;
   assign u_p = lp[0] ^ pol;
   assign u_n = ln[0] ^ pol;
   assign v_p = lp[1] ^ pol;
   assign v_n = ln[1] ^ pol;
   assign w_p = lp[2] ^ pol;
   assign w_n = ln[2] ^ pol;

   // R10: pins of a pair are inverted together by polarity
   a_r10_pol_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (pol && lp[0] && ln[0]) |-> (!u_p && !u_n));
endmodule

// File: tb/sim_tri_saw_pwm.sv
module sim_tri_saw_pwm;
   localparam int CW  = 16;
   localparam int DTW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [CW-1:0] wr_data = '0;
   logic cz, up, un, vp, vn, wp, wn;

   always #2 clk = ~clk;

   tri_saw_pwm #(.CW(CW), .DTW(DTW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .carrier_zero(cz), .u_p(up), .u_n(un), .v_p(vp), .v_n(vn), .w_p(wp), .w_n(wn)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  ended = 0;

   task automatic chk(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic finish_sim();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_sim();
   end

   // ---------------- reference model (from the requirements) ----------------
   int         m_cnt, m_per, m_dt, m_wid[3], m_aw[3], m_t[3];
   bit         m_pol;
   logic [11:0] m_buf;
   logic [3:0] m_lat[3];
   bit         m_seg[3];
   int         m_rem[3][2];

   function automatic bit mlvl(int p, int s);
      bit b;
      b = m_lat[p][s*2 + (m_seg[p] ? 1 : 0)];
      return b | (m_rem[p][s] > 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 0; m_dt = 0; m_pol = 0; m_buf = 12'hFFF;
         for (int p = 0; p < 3; p++) begin
            m_wid[p] = 0; m_aw[p] = 0; m_t[p] = 0; m_lat[p] = 4'hF; m_seg[p] = 1;
            m_rem[p][0] = 0; m_rem[p][1] = 0;
         end
      end else begin
         bit z;
         z = (m_cnt == 0);
         for (int p = 0; p < 3; p++) begin
            bit ev, o0, o1, nb;
            o0 = mlvl(p, 0);
            o1 = mlvl(p, 1);
            ev = 0;
            if (z) begin
               m_lat[p] = m_buf[4*p +: 4]; m_seg[p] = 0; m_t[p] = 0; m_aw[p] = m_wid[p]; ev = 1;
            end else begin
               if (!m_seg[p] && m_t[p] == m_aw[p]) begin m_seg[p] = 1; ev = 1; end
               if (m_t[p] < 1000000) m_t[p]++;
            end
            for (int s = 0; s < 2; s++) begin
               if (ev) begin
                  nb = m_lat[p][s*2 + (m_seg[p] ? 1 : 0)];
                  m_rem[p][s] = ((s == 0 ? o0 : o1) && !nb) ? m_dt + 1 : 0;
               end else if (m_rem[p][s] > 0) begin
                  m_rem[p][s]--;
               end
            end
         end
         m_cnt = z ? m_per : m_cnt - 1;
         if (wr_en) begin
            case (wr_sel)
               3'd0: m_per = int'(wr_data);
               3'd1: m_dt  = int'(wr_data[DTW-1:0]);
               3'd2: m_buf = wr_data[11:0];
               3'd3: m_pol = wr_data[0];
               3'd4: m_wid[0] = int'(wr_data);
               3'd5: m_wid[1] = int'(wr_data);
               3'd6: m_wid[2] = int'(wr_data);
               default: ;
            endcase
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic wr_reg(input logic [2:0] sel, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   // returns at a negedge with carrier_zero high; count = negedges waited
   task automatic wait_zero(output int n);
      n = 0;
      do begin
         @(negedge clk);
         wr_en = 0;
         n++;
      end while (cz !== 1'b1);
   endtask

   // mode 0: advance at k=4; mode 1: no advance after mode 0; mode 2: no advance steady
   function automatic bit e_pos(int mode, int k);
      return (mode == 0) ? (k < 7) : 1'b1;
   endfunction
   function automatic bit e_neg(int mode, int k);
      if (mode == 0) return (k != 3);
      if (mode == 1) return (k < 3);
      return 1'b0;
   endfunction

   // called at a zero negedge; checks the 10 cycles of the next period (P=9, D=2, W=3)
   task automatic check_period(input int umode, input bit pl);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         wr_en = 0;
         if (umode == 0) begin
            chk(k < 4 ? "R2 u_p" : (k < 7 ? "R4 u_p held" : "R3 u_p"), up, e_pos(0, k) ^ pl);
            chk(k < 3 ? "R4 u_n held" : (k == 3 ? "R2 u_n" : "R5 u_n rise"), un, e_neg(0, k) ^ pl);
         end else begin
            chk(umode == 1 ? "R9 u_p" : "R10 u_p", up, e_pos(umode, k) ^ pl);
            chk(umode == 1 ? "R9 u_n" : "R10 u_n", un, e_neg(umode, k) ^ pl);
         end
         chk("R3 v_p", vp, e_pos(0, k) ^ pl);
         chk("R4 v_n", vn, e_neg(0, k) ^ pl);
         chk("R6 v pair", (vp ^ pl) | (vn ^ pl), 1'b1);
         chk("R7 w_n", wn, 1'b1 ^ pl);
         chk("R3 w_p", wp, e_pos(0, k) ^ pl);
      end
   endtask

   bit cmp_on = 0;

   initial begin
      int n;
      void'($urandom(32'd20240611));
      rst_n = 0;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R11 u_p", up, 1'b1); chk("R11 u_n", un, 1'b1);
      chk("R11 v_p", vp, 1'b1); chk("R11 v_n", vn, 1'b1);
      chk("R11 w_p", wp, 1'b1); chk("R11 w_n", wn, 1'b1);
      chk("R11 carrier_zero", cz, 1'b1);

      // buffers: U,V = pos 01 / neg 10 (nibble 9); W = pos 01 / neg 11 (nibble D)
      wr_reg(3'd2, 16'h0D99);
      wr_reg(3'd4, 16'd3);
      wr_reg(3'd5, 16'd3);
      wr_reg(3'd6, 16'd3);
      wr_reg(3'd1, 16'd2);
      wr_reg(3'd0, 16'd9);
      wait_zero(n);
      wait_zero(n);
      chk_int("R1 zero spacing", n, 10);

      check_period(0, 1'b0);
      // R8: width write lands on the load edge; this period keeps the old width
      wr_en = 1; wr_sel = 3'd4; wr_data = 16'd9;
      check_period(0, 1'b0);
      // R9: width equals period, no advance
      check_period(1, 1'b0);
      // R10: polarity write
      wr_en = 1; wr_sel = 3'd3; wr_data = 16'd1;
      check_period(2, 1'b1);
      // R12: select 7 must not touch anything
      wr_en = 1; wr_sel = 3'd7; wr_data = 16'd0;
      wait_zero(n);
      chk_int("R12 spacing after select 7", n, 10);
      chk("R12 w_n unchanged", wn, 1'b0);

      // random phase against the model
      cmp_on = 1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         chk("R1 carrier_zero", cz, m_cnt == 0);
         chk("R2/R3/R4/R5 u_p", up, mlvl(0, 0) ^ m_pol);
         chk("R2/R3/R4/R5 u_n", un, mlvl(0, 1) ^ m_pol);
         chk("R8/R9 v_p", vp, mlvl(1, 0) ^ m_pol);
         chk("R8/R9 v_n", vn, mlvl(1, 1) ^ m_pol);
         chk("R10/R12 w_p", wp, mlvl(2, 0) ^ m_pol);
         chk("R10/R12 w_n", wn, mlvl(2, 1) ^ m_pol);
         if ($urandom % 6 == 0) begin
            logic [2:0] s;
            s = 3'($urandom % 8);
            wr_en = 1; wr_sel = s;
            case (s)
               3'd0:    wr_data = 16'($urandom % 18);
               3'd1:    wr_data = 16'($urandom % 6);
               3'd2:    wr_data = 16'($urandom % 4096);
               3'd3:    wr_data = 16'($urandom % 2);
               3'd7:    wr_data = 16'($urandom);
               default: wr_data = 16'($urandom % 24);
            endcase
         end else begin
            wr_en = 0;
         end
      end
      @(negedge clk);
      wr_en = 0;
      finish_sim();
   end
endmodule